// File: doc/BRIEF.md
# Clock Start-Up and Switchover Sequencer

This block decides which oscillator clocks the core after a reset or a wake from a power-managed mode, and when the core may run. Two sources are available. One is a primary oscillator whose crystal and resonator modes need a start-up count before they can be trusted. The other is an internal oscillator that is always running. The sequencer counts primary oscillator cycles with its own start-up timer and holds the core while it waits. When a fast-start option is enabled, it instead releases the core at once on the internal clock and hands over to the primary clock once that clock is ready.

The switch to the primary clock always passes through a single handoff cycle in which the core is held, so the select output never moves while an instruction is running. The start-up count is skipped when the primary source is a non-crystal mode, when the internal oscillator is the chosen source, and when the primary clock was kept running through an idle period. A wake that skips the count still holds the core for a short fixed preparation delay. If a power-managed mode is requested before the primary clock is ready, the primary oscillator is shut down.

Top module: `clk_startup_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, core_hold is 1, clk_sel is 0 (0 = internal, 1 = primary), and pri_shutdown, pri_stable and int_stable are 0.
- R2: For the crystal modes (pri_mode 0 to 3) with both fast-start enables low, the core stays held until OST_CYCLES pri_tick pulses have been counted. The cycle after the last pulse is a handoff cycle with pri_stable 1, and in the next cycle the core runs with clk_sel 1.
- R3: For a crystal mode with two_speed_en or failsafe_en high, the cycle after boot releases the core on the internal clock (core_hold 0, clk_sel 0, int_stable 1) while the start-up count proceeds.
- R4: In early-release running, the pri_tick that completes the count leads to one handoff cycle with core_hold 1, clk_sel 0, pri_stable 1 and int_stable 0. The next cycle has clk_sel 1 and core_hold 0. pri_stable and int_stable are never both 1.
- R5: clk_sel rises only in a cycle whose previous cycle had core_hold 1.
- R6: A pm_req during early-release running enters sleep with pri_shutdown 1, core_hold 1 and all status bits 0. This holds even when pm_keep_pri is high, because the primary clock is not yet ready.
- R7: With pri_mode 6 (internal oscillator as source), the core runs on the internal clock from the cycle after boot, pri_tick has no effect, and clk_sel stays 0.
- R8: With pri_mode 4, 5 or 7 (non-crystal primary), no count is made: the cycle after boot is the handoff cycle, whatever the fast-start enables are.
- R9: A pm_req with pm_keep_pri high while running on the primary clock enters primary-idle with pri_shutdown 0, pri_stable 1, clk_sel 1 and core_hold 1. A wake then resumes on the primary clock without any pri_tick.
- R10: The start-up count begins from zero at every launch, and pri_tick pulses outside the counting states, such as during sleep, are not counted.
- R11: A wake that skips the count (primary-idle, non-crystal, or internal source) holds the core for exactly CSD_CYCLES cycles before it runs on the intended clock. pri_stable is 1 during that delay only when the primary clock was kept running.
- R12: A pm_req or wake arriving while the core is held and not asleep is ignored: pri_shutdown stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, from the always-running internal oscillator |
| rst_n | input | 1 | Asynchronous active-low reset source |
| pri_mode | input | 3 | Primary source mode: 0-3 crystal, 4 RC, 5 external, 6 internal, 7 external |
| pri_tick | input | 1 | One pulse per primary oscillator cycle, already synchronised |
| two_speed_en | input | 1 | Enables early release on the internal clock |
| failsafe_en | input | 1 | Fail-safe monitor enabled; also allows early release |
| pm_req | input | 1 | Request to enter a power-managed mode |
| pm_keep_pri | input | 1 | With pm_req: keep the primary clock running (idle) |
| wake | input | 1 | Wake event ending a power-managed mode |
| clk_sel | output | 1 | Core clock select: 0 internal, 1 primary |
| core_hold | output | 1 | Holds the core from executing |
| pri_shutdown | output | 1 | Requests that the primary oscillator be stopped |
| pri_stable | output | 1 | Primary clock is ready and selected or about to be selected |
| int_stable | output | 1 | Internal clock is the running core clock |

## Verification
The launch decision is driven with each class of primary mode: a plain crystal, a crystal with either fast-start enable, a non-crystal mode, the alternate external code and the internal source. Together these runs separate the held-for-count path, the early-release path and the no-count path. Sleep is entered once with pulses arriving during sleep and a partly finished count, so that a counter that is not restarted, or one that counts while idle, reaches handoff early. Primary-idle and full sleep are each woken on the same non-crystal source, which separates the kept-running status from the restarted one. Each wake delay is sampled one cycle before and at its expected end.

// File: rtl/clk_seq_pkg.sv
package clk_seq_pkg;

   typedef enum logic [2:0] {
      MODE_XTAL_LOW  = 3'd0,
      MODE_XTAL_MID  = 3'd1,
      MODE_XTAL_HIGH = 3'd2,
      MODE_XTAL_PLL  = 3'd3,
      MODE_RC        = 3'd4,
      MODE_EXT       = 3'd5,
      MODE_INTERNAL  = 3'd6,
      MODE_EXT_ALT   = 3'd7
   } src_mode_e;

   typedef enum logic [3:0] {
      SQ_BOOT     = 4'd0,
      SQ_WAIT     = 4'd1,
      SQ_EARLY    = 4'd2,
      SQ_HANDOFF  = 4'd3,
      SQ_RUN_PRI  = 4'd4,
      SQ_RUN_INT  = 4'd5,
      SQ_SLEEP    = 4'd6,
      SQ_IDLE_PRI = 4'd7,
      SQ_WAKE_DLY = 4'd8
   } seq_state_e;

endpackage

// File: rtl/clk_seq_counter.sv
module clk_seq_counter #(
   parameter int unsigned LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic inc,
   output logic done
);
   localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

   if (LIMIT < 1) begin : g_bad_limit
      $error("clk_seq_counter: LIMIT must be at least 1");
   end

   if (LIMIT == 1) begin : g_single
      // a single event finishes the interval, no storage needed
      assign done = run & inc;
   end else begin : g_count
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 cnt_q <= '0;
         else if (!run)                              cnt_q <= '0;
         else if (inc && (cnt_q != CW'(LIMIT - 1))) cnt_q <= cnt_q + 1'b1;
      end

      // done fires on the edge that consumes the LIMIT-th event
      assign done = run & inc & (cnt_q == CW'(LIMIT - 1));

      a_r10_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(run) |-> (cnt_q == '0));
   end

endmodule

// File: rtl/clk_seq_mode_dec.sv
module clk_seq_mode_dec
   import clk_seq_pkg::*;
(
   input  logic [2:0] mode,
   output logic       needs_count,
   output logic       on_internal
);
   src_mode_e m;

   always_comb begin
      m           = src_mode_e'(mode);
      needs_count = 1'b0;
      on_internal = 1'b0;
      unique case (m)
         MODE_XTAL_LOW, MODE_XTAL_MID,
         MODE_XTAL_HIGH, MODE_XTAL_PLL: needs_count = 1'b1;
         MODE_INTERNAL:                  on_internal = 1'b1;
         default:                        ;
      endcase
   end

endmodule

// File: rtl/clk_startup_seq.sv
module clk_startup_seq
   import clk_seq_pkg::*;
#(
   parameter int unsigned OST_CYCLES = 1024,
   parameter int unsigned CSD_CYCLES = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] pri_mode,
   input  logic       pri_tick,
   input  logic       two_speed_en,
   input  logic       failsafe_en,
   input  logic       pm_req,
   input  logic       pm_keep_pri,
   input  logic       wake,
   output logic       clk_sel,
   output logic       core_hold,
   output logic       pri_shutdown,
   output logic       pri_stable,
   output logic       int_stable
);
   if (OST_CYCLES < 1) begin : g_bad_ost
      $error("clk_startup_seq: OST_CYCLES must be at least 1");
   end
   if (CSD_CYCLES < 1) begin : g_bad_csd
      $error("clk_startup_seq: CSD_CYCLES must be at least 1");
   end

   seq_state_e state_q, state_d;
   logic       dest_pri_q, dest_pri_d;
   logic       from_idle_q, from_idle_d;
   logic       needs_count, on_internal, fast_start;
   logic       ost_run, ost_done, dly_run, dly_done;

   clk_seq_mode_dec u_dec (
      .mode        (pri_mode),
      .needs_count (needs_count),
      .on_internal (on_internal)
   );

   assign ost_run = (state_q == SQ_WAIT) || (state_q == SQ_EARLY);
   assign dly_run = (state_q == SQ_WAKE_DLY);

   clk_seq_counter #(.LIMIT(OST_CYCLES)) u_ost (
      .clk (clk), .rst_n (rst_n), .run (ost_run), .inc (pri_tick), .done (ost_done)
   );

   clk_seq_counter #(.LIMIT(CSD_CYCLES)) u_dly (
      .clk (clk), .rst_n (rst_n), .run (dly_run), .inc (1'b1), .done (dly_done)
   );

   assign fast_start = two_speed_en | failsafe_en;

   always_comb begin
      state_d     = state_q;
      dest_pri_d  = dest_pri_q;
      from_idle_d = from_idle_q;
      unique case (state_q)
         SQ_BOOT: begin
            if (on_internal)       state_d = SQ_RUN_INT;
            else if (!needs_count) state_d = SQ_HANDOFF;
            else if (fast_start)   state_d = SQ_EARLY;
            else                   state_d = SQ_WAIT;
         end
         SQ_WAIT:    if (ost_done) state_d = SQ_HANDOFF;
         SQ_EARLY: begin
            // entering a low-power mode before the primary is ready stops it
            if (pm_req)        state_d = SQ_SLEEP;
            else if (ost_done) state_d = SQ_HANDOFF;
         end
         SQ_HANDOFF: state_d = SQ_RUN_PRI;
         SQ_RUN_PRI: if (pm_req) state_d = pm_keep_pri ? SQ_IDLE_PRI : SQ_SLEEP;
         SQ_RUN_INT: if (pm_req) state_d = SQ_SLEEP;
         SQ_SLEEP: begin
            if (wake) begin
               if (on_internal) begin
                  state_d = SQ_WAKE_DLY; dest_pri_d = 1'b0; from_idle_d = 1'b0;
               end else if (!needs_count) begin
                  state_d = SQ_WAKE_DLY; dest_pri_d = 1'b1; from_idle_d = 1'b0;
               end else if (fast_start) begin
                  state_d = SQ_EARLY;
               end else begin
                  state_d = SQ_WAIT;
               end
            end
         end
         SQ_IDLE_PRI: begin
            if (wake) begin
               state_d = SQ_WAKE_DLY; dest_pri_d = 1'b1; from_idle_d = 1'b1;
            end
         end
         SQ_WAKE_DLY: if (dly_done) state_d = dest_pri_q ? SQ_RUN_PRI : SQ_RUN_INT;
         default:    state_d = SQ_BOOT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= SQ_BOOT;
         dest_pri_q  <= 1'b0;
         from_idle_q <= 1'b0;
      end else begin
         state_q     <= state_d;
         dest_pri_q  <= dest_pri_d;
         from_idle_q <= from_idle_d;
      end
   end

   always_comb begin
      core_hold    = !((state_q == SQ_EARLY) || (state_q == SQ_RUN_PRI) ||
                       (state_q == SQ_RUN_INT));
      clk_sel      = (state_q == SQ_RUN_PRI) || (state_q == SQ_IDLE_PRI) ||
                     ((state_q == SQ_WAKE_DLY) && dest_pri_q);
      pri_shutdown = (state_q == SQ_SLEEP);
      pri_stable   = (state_q == SQ_HANDOFF) || (state_q == SQ_RUN_PRI) ||
                     (state_q == SQ_IDLE_PRI) ||
                     ((state_q == SQ_WAKE_DLY) && from_idle_q);
      int_stable   = (state_q == SQ_EARLY) || (state_q == SQ_RUN_INT) ||
                     ((state_q == SQ_WAKE_DLY) && !dest_pri_q);
   end

   // R5: the select moves only after a cycle with the core held
   a_r5_sel_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_sel) |-> $past(core_hold));

   // R6: a stopped primary implies a held core and no stable source
   a_r6_shutdown_held: assert property (@(posedge clk) disable iff (!rst_n)
      pri_shutdown |-> (core_hold && !pri_stable && !int_stable && !clk_sel));

   // R4: at most one source reports stable
   a_r4_single_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !(pri_stable && int_stable));

   // R12: shutdown is entered only from a running core
   a_r12_shutdown_from_run: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pri_shutdown) |-> !$past(core_hold));

endmodule

// File: tb/clk_startup_seq_tb_top.sv
`timescale 1ns/1ps
module clk_startup_seq_tb_top;
   localparam int unsigned L = 12;
   localparam int unsigned D = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] pri_mode = 3'd0;
   logic       pri_tick = 1'b0, two_speed_en = 1'b0, failsafe_en = 1'b0;
   logic       pm_req = 1'b0, pm_keep_pri = 1'b0, wake = 1'b0;
   logic       clk_sel, core_hold, pri_shutdown, pri_stable, int_stable;

   int n_chk = 0;
   int n_fail = 0;
   bit done_flag = 1'b0;

   always #2.5 clk = ~clk;

   clk_startup_seq #(.OST_CYCLES(L), .CSD_CYCLES(D)) dut_i (
      .clk (clk), .rst_n (rst_n), .pri_mode (pri_mode), .pri_tick (pri_tick),
      .two_speed_en (two_speed_en), .failsafe_en (failsafe_en),
      .pm_req (pm_req), .pm_keep_pri (pm_keep_pri), .wake (wake),
      .clk_sel (clk_sel), .core_hold (core_hold), .pri_shutdown (pri_shutdown),
      .pri_stable (pri_stable), .int_stable (int_stable)
   );

   // order: {core_hold, clk_sel, pri_shutdown, pri_stable, int_stable}
   task automatic expect_out(input string req, input logic [4:0] exp);
      logic [4:0] act;
      act = {core_hold, clk_sel, pri_shutdown, pri_stable, int_stable};
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: outputs %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic do_reset(input logic [2:0] m, input logic ts, input logic fs);
      rst_n = 1'b0; pri_mode = m; two_speed_en = ts; failsafe_en = fs;
      pri_tick = 1'b0; pm_req = 1'b0; pm_keep_pri = 1'b0; wake = 1'b0;
      #1;
      expect_out("R1 in reset", 5'b10000);
      step(3);
      rst_n = 1'b1;
      expect_out("R1 boot", 5'b10000);
   endtask

   task automatic t_plain_xtal();
      do_reset(3'd1, 1'b0, 1'b0);
      step(1);
      expect_out("R2 waiting", 5'b10000);
      pm_req = 1'b1; wake = 1'b1;
      step(2);
      expect_out("R12 request ignored while held", 5'b10000);
      pm_req = 1'b0; wake = 1'b0; pri_tick = 1'b1;
      step(L - 1);
      expect_out("R2 one tick short", 5'b10000);
      step(1);
      expect_out("R2 handoff", 5'b10010);
      pri_tick = 1'b0;
      step(1);
      expect_out("R2 run primary", 5'b01010);
   endtask

   task automatic t_two_speed();
      do_reset(3'd2, 1'b1, 1'b0);
      step(1);
      expect_out("R3 early release", 5'b00001);
      pri_tick = 1'b1;
      step(L - 1);
      expect_out("R3 still internal", 5'b00001);
      step(1);
      expect_out("R4 handoff cycle", 5'b10010);
      pri_tick = 1'b0;
      step(1);
      expect_out("R4 R5 switched to primary", 5'b01010);
   endtask

   task automatic t_failsafe_sleep();
      do_reset(3'd0, 1'b0, 1'b1);
      step(1);
      expect_out("R3 failsafe early release", 5'b00001);
      pri_tick = 1'b1;
      step(5);
      pri_tick = 1'b0; pm_req = 1'b1; pm_keep_pri = 1'b1;
      step(1);
      expect_out("R6 sleep before ready", 5'b10100);
      pm_req = 1'b0; pm_keep_pri = 1'b0; pri_tick = 1'b1;
      step(L + 8);
      expect_out("R10 ticks in sleep ignored", 5'b10100);
      pri_tick = 1'b0; wake = 1'b1;
      step(1);
      expect_out("R10 relaunch early", 5'b00001);
      wake = 1'b0; pri_tick = 1'b1;
      step(L - 1);
      expect_out("R10 count restarted", 5'b00001);
      step(1);
      expect_out("R10 handoff after full count", 5'b10010);
      pri_tick = 1'b0;
   endtask

   task automatic t_internal();
      do_reset(3'd6, 1'b1, 1'b0);
      step(1);
      expect_out("R7 run internal", 5'b00001);
      pri_tick = 1'b1;
      step(L + 2);
      expect_out("R7 ticks no effect", 5'b00001);
      pri_tick = 1'b0; pm_req = 1'b1;
      step(1);
      expect_out("R7 sleep", 5'b10100);
      pm_req = 1'b0; wake = 1'b1;
      step(1);
      expect_out("R11 wake delay internal", 5'b10001);
      wake = 1'b0;
      step(D - 1);
      expect_out("R11 delay end minus one", 5'b10001);
      step(1);
      expect_out("R11 resume internal", 5'b00001);
   endtask

   task automatic t_rc_idle();
      do_reset(3'd4, 1'b1, 1'b1);
      step(1);
      expect_out("R8 rc direct handoff", 5'b10010);
      step(1);
      expect_out("R8 rc run primary", 5'b01010);
      pm_req = 1'b1; pm_keep_pri = 1'b1;
      step(1);
      expect_out("R9 primary idle", 5'b11010);
      pm_req = 1'b0; pm_keep_pri = 1'b0; wake = 1'b1;
      step(1);
      expect_out("R9 wake delay kept primary", 5'b11010);
      wake = 1'b0;
      step(D - 1);
      expect_out("R11 idle delay end minus one", 5'b11010);
      step(1);
      expect_out("R9 resume primary", 5'b01010);
      pm_req = 1'b1;
      step(1);
      expect_out("R11 full sleep", 5'b10100);
      pm_req = 1'b0; wake = 1'b1;
      step(1);
      expect_out("R11 wake delay restarted primary", 5'b11000);
      wake = 1'b0;
      step(D - 1);
      expect_out("R11 sleep delay end minus one", 5'b11000);
      step(1);
      expect_out("R11 resume primary after sleep", 5'b01010);
   endtask

   task automatic t_ext_alt();
      do_reset(3'd7, 1'b0, 1'b1);
      step(1);
      expect_out("R8 code 7 direct handoff", 5'b10010);
      step(1);
      expect_out("R8 code 7 run primary", 5'b01010);
      do_reset(3'd5, 1'b1, 1'b0);
      step(1);
      expect_out("R8 external direct handoff", 5'b10010);
   endtask

   initial begin
      t_plain_xtal();
      t_two_speed();
      t_failsafe_sleep();
      t_internal();
      t_rc_idle();
      t_ext_alt();
      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done_flag) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run hung, actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule